// File: doc/BRIEF.md
# Queued Flash Command Sequencer

This block is the command front end and write engine of a small block-erasable flash array. Bus writes carry either an opcode or, in the second cycle of a sequence, the address and data that the opcode acts on. Program and erase each need two writes: a setup write and then a confirm write. Once decoded, an operation goes into a single pending slot. From there it passes to one of two engines. The program engine takes one word at a time. The erase engine clears one block, or sweeps every unlocked block in turn. The two engines can run at the same time, provided they are working on different blocks.

Each block has a lock bit. While the write-protect input is high, any program or erase aimed at a locked block is refused and recorded in that block's failure bit. The storage is a register array of sixteen blocks. Program and erase take fixed numbers of clock cycles, each set by a parameter. The block reports progress in three ways: an active-low busy flag, a compatible status byte and a global status byte. It also gives three per-block status vectors: lock, failure and busy. Every word of the array can be read back combinationally through a separate read port.

The command port is valid/ready, but `cmd_ready` is held high at all times, so the block never applies back-pressure. A write that cannot be taken is instead dropped and flagged as a sequence error.

Top module: `flq_seq`

## Requirements
- R1: Command opcodes sit in `cmd_data[7:0]`. The setup codes are 0x40 (program), 0x20 (block erase), 0xA7 (erase all unlocked), 0x60 (lock change) and 0x50 (clear status, one write only). For program, the next write supplies the address and data. Erase and erase-all need 0xD0 as the confirm write, and the erase target is the block given by the confirm write's address. Any other confirm sets the sequence-error flag and starts nothing.
- R2: A block erase sets every word of the target block to all ones and leaves every other block unchanged.
- R3: Programming ANDs the new data into the stored word, so a program can only clear bits.
- R4: One operation can wait in the pending slot while the engines are busy. An operation that arrives while the slot is full is dropped and sets the sequence-error flag.
- R5: A program and an erase run at the same time when they target different blocks. A program aimed at the block under erase waits until that erase has finished.
- R6: A lock change uses 0x60 then 0x01 to set the lock and 0x60 then 0xD0 to clear it, on the block given by the confirm address. While `wr_protect` is high, a program or erase aimed at a locked block is refused: it sets that block's `blk_fail` bit and the program-fail or erase-fail status bit, and leaves the array unchanged. While `wr_protect` is low, a locked block can be modified.
- R7: Erase-all erases every block whose lock bit is clear and skips every locked block, whatever the level of `wr_protect`.
- R8: `busy_n` is low whenever an operation is pending or executing, and high otherwise.
- R9: The compatible status byte `csr` is laid out as: bit 7 ready, bit 5 erase failed, bit 4 program failed, bit 3 sequence error, all other bits zero. The global status byte `gsr` is laid out as: bit 7 ready, bit 3 queue full, bit 2 erase engine active, bit 1 program engine active, bit 0 sequence error, all other bits zero.
- R10: The failure bits and the sequence-error flag are sticky. Only a clear-status command clears them.
- R11: A program keeps the program engine active for exactly PROG_CYCLES cycles. A block erase keeps the erase engine active for exactly ERASE_CYCLES cycles.
- R12: `cmd_ready` is always high. A write counts when `cmd_valid` is high on a rising clock edge.
- R13: After reset, the array reads all ones, no block is locked or failed, `busy_n` is high, and both status bytes read 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Bus write strobe |
| cmd_ready | output | 1 | Always high |
| cmd_addr | input | ADDR_W (7) | {block, word} address |
| cmd_data | input | DATA_W (16) | Opcode or program data |
| wr_protect | input | 1 | Makes lock bits take effect |
| rd_addr | input | ADDR_W (7) | Read address |
| rd_data | output | DATA_W (16) | Array word at rd_addr |
| busy_n | output | 1 | Low while any work is pending or executing |
| csr | output | 8 | Compatible status |
| gsr | output | 8 | Global status |
| blk_lock | output | NUM_BLOCKS | Lock bit per block |
| blk_fail | output | NUM_BLOCKS | Sticky refusal bit per block |
| blk_busy | output | NUM_BLOCKS | Block under program or erase |

## Verification
The bench programs the same word twice with overlapping bit patterns, which separates an AND merge from a plain overwrite. It erases one block next to a programmed neighbour, which confirms that an erase stays inside its own block. To tell real queuing from serial acceptance, it fills the pending slot behind a running erase and checks that the third operation is dropped. It also programs the block that is being erased and checks that the word holds the program data afterwards, which exposes any reordering. Finally, locked blocks are tried with protection both high and low, and erase-all is run with one block locked.

// File: rtl/flq_pkg.sv
package flq_pkg;
  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_EALL} op_kind_t;

  localparam logic [7:0] OPC_PROG  = 8'h40;
  localparam logic [7:0] OPC_ERASE = 8'h20;
  localparam logic [7:0] OPC_EALL  = 8'hA7;
  localparam logic [7:0] OPC_LOCK  = 8'h60;
  localparam logic [7:0] OPC_CLR   = 8'h50;
  localparam logic [7:0] OPC_CONF  = 8'hD0;
  localparam logic [7:0] OPC_LKSET = 8'h01;
endpackage

// File: rtl/flq_cmd_decode.sv
module flq_cmd_decode
  import flq_pkg::*;
#(
  parameter int BLK_AW  = 4,
  parameter int WORD_AW = 3,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = BLK_AW + WORD_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  output logic               req_valid,
  output op_kind_t           req_kind,
  output logic [BLK_AW-1:0]  req_blk,
  output logic [WORD_AW-1:0] req_word,
  output logic [DATA_W-1:0]  req_data,
  output logic               lock_set,
  output logic               lock_clr,
  output logic               clr_stat,
  output logic               bad_seq
);
  typedef enum logic [2:0] {D_IDLE, D_PROG, D_ERASE, D_EALL, D_LOCK} dec_st_t;

  dec_st_t st, st_nxt;
  logic [7:0] op;

  assign op       = cmd_data[7:0];
  assign req_blk  = cmd_addr[ADDR_W-1:WORD_AW];
  assign req_word = cmd_addr[WORD_AW-1:0];
  assign req_data = cmd_data;

  always_comb begin
    st_nxt    = st;
    req_valid = 1'b0;
    req_kind  = OP_PROG;
    lock_set  = 1'b0;
    lock_clr  = 1'b0;
    clr_stat  = 1'b0;
    bad_seq   = 1'b0;
    if (cmd_valid) begin
      case (st)
        D_IDLE: begin
          case (op)
            OPC_PROG:  st_nxt = D_PROG;
            OPC_ERASE: st_nxt = D_ERASE;
            OPC_EALL:  st_nxt = D_EALL;
            OPC_LOCK:  st_nxt = D_LOCK;
            OPC_CLR:   clr_stat = 1'b1;
            default:   st_nxt = D_IDLE;
          endcase
        end
        D_PROG: begin
          req_valid = 1'b1;
          req_kind  = OP_PROG;
          st_nxt    = D_IDLE;
        end
        D_ERASE: begin
          if (op == OPC_CONF) begin
            req_valid = 1'b1;
            req_kind  = OP_ERASE;
          end else begin
            bad_seq = 1'b1;
          end
          st_nxt = D_IDLE;
        end
        D_EALL: begin
          if (op == OPC_CONF) begin
            req_valid = 1'b1;
            req_kind  = OP_EALL;
          end else begin
            bad_seq = 1'b1;
          end
          st_nxt = D_IDLE;
        end
        D_LOCK: begin
          if (op == OPC_LKSET)     lock_set = 1'b1;
          else if (op == OPC_CONF) lock_clr = 1'b1;
          else                     bad_seq  = 1'b1;
          st_nxt = D_IDLE;
        end
        default: st_nxt = D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= D_IDLE;
    else        st <= st_nxt;
  end
endmodule

// File: rtl/flq_prog_eng.sv
module flq_prog_eng #(
  parameter int BLK_AW      = 4,
  parameter int WORD_AW     = 3,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 4,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLK_AW-1:0]  blk,
  input  logic [WORD_AW-1:0] word,
  input  logic [DATA_W-1:0]  data,
  output logic               busy,
  output logic [BLK_AW-1:0]  cur_blk,
  output logic               wr_en,
  output logic [WORD_AW-1:0] wr_word,
  output logic [DATA_W-1:0]  wr_data
);
  logic [CNT_W-1:0] cnt;

  assign wr_en = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cur_blk <= '0;
      wr_word <= '0;
      wr_data <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy    <= 1'b1;
      cnt     <= CNT_W'(PROG_CYCLES - 1);
      cur_blk <= blk;
      wr_word <= word;
      wr_data <= data;
    end
  end
endmodule

// File: rtl/flq_erase_eng.sv
module flq_erase_eng #(
  parameter int NUM_BLOCKS   = 16,
  parameter int BLK_AW       = 4,
  parameter int ERASE_CYCLES = 12,
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  all_mode,
  input  logic [BLK_AW-1:0]     blk,
  input  logic [NUM_BLOCKS-1:0] lock,
  input  logic                  prog_busy,
  input  logic [BLK_AW-1:0]     prog_blk,
  output logic                  busy,
  output logic                  running,
  output logic [BLK_AW-1:0]     cur_blk,
  output logic                  wipe_en
);
  typedef enum logic [1:0] {E_IDLE, E_SCAN, E_RUN} er_st_t;
  localparam logic [BLK_AW-1:0] LAST_BLK = BLK_AW'(NUM_BLOCKS - 1);

  er_st_t st;
  logic [CNT_W-1:0] cnt;
  logic sweep;

  assign busy    = (st != E_IDLE);
  assign running = (st == E_RUN);
  assign wipe_en = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cnt     <= '0;
      cur_blk <= '0;
      sweep   <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          sweep <= all_mode;
          if (all_mode) begin
            cur_blk <= '0;
            st      <= E_SCAN;
          end else begin
            cur_blk <= blk;
            cnt     <= CNT_W'(ERASE_CYCLES - 1);
            st      <= E_RUN;
          end
        end
        E_SCAN: begin
          if (lock[cur_blk]) begin
            if (cur_blk == LAST_BLK) st <= E_IDLE;
            else                     cur_blk <= cur_blk + 1'b1;
          end else if (!(prog_busy && prog_blk == cur_blk)) begin
            cnt <= CNT_W'(ERASE_CYCLES - 1);
            st  <= E_RUN;
          end
        end
        E_RUN: begin
          if (cnt == '0) begin
            if (sweep && cur_blk != LAST_BLK) begin
              cur_blk <= cur_blk + 1'b1;
              st      <= E_SCAN;
            end else begin
              st <= E_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flq_array.sv
module flq_array #(
  parameter int NUM_BLOCKS      = 16,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int DATA_W          = 16,
  localparam int BLK_AW  = $clog2(NUM_BLOCKS),
  localparam int WORD_AW = $clog2(WORDS_PER_BLOCK),
  localparam int ADDR_W  = BLK_AW + WORD_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BLK_AW-1:0]  wr_blk,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wipe_en,
  input  logic [BLK_AW-1:0]  wipe_blk,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  logic [DATA_W-1:0] blk_rd [NUM_BLOCKS];
  logic [WORD_AW-1:0] rd_word;
  logic [BLK_AW-1:0]  rd_blk;

  assign rd_word = rd_addr[WORD_AW-1:0];
  assign rd_blk  = rd_addr[ADDR_W-1:WORD_AW];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [DATA_W-1:0] words [WORDS_PER_BLOCK];
    always_ff @(posedge clk) begin
      if (!rst_n || (wipe_en && wipe_blk == BLK_AW'(b))) begin
        for (int w = 0; w < WORDS_PER_BLOCK; w++) words[w] <= '1;
      end else if (wr_en && wr_blk == BLK_AW'(b)) begin
        words[wr_word] <= words[wr_word] & wr_data;
      end
    end
    assign blk_rd[b] = words[rd_word];
  end

  assign rd_data = blk_rd[rd_blk];
endmodule

// File: rtl/flq_seq.sv
module flq_seq
  import flq_pkg::*;
#(
  parameter int NUM_BLOCKS      = 16,
  parameter int WORDS_PER_BLOCK = 8,
  parameter int DATA_W          = 16,
  parameter int PROG_CYCLES     = 4,
  parameter int ERASE_CYCLES    = 12,
  localparam int BLK_AW  = $clog2(NUM_BLOCKS),
  localparam int WORD_AW = $clog2(WORDS_PER_BLOCK),
  localparam int ADDR_W  = BLK_AW + WORD_AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic                  wr_protect,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  busy_n,
  output logic [7:0]            csr,
  output logic [7:0]            gsr,
  output logic [NUM_BLOCKS-1:0] blk_lock,
  output logic [NUM_BLOCKS-1:0] blk_fail,
  output logic [NUM_BLOCKS-1:0] blk_busy
);
  logic               req_valid, lock_set, lock_clr, clr_stat, bad_seq;
  op_kind_t           req_kind;
  logic [BLK_AW-1:0]  req_blk;
  logic [WORD_AW-1:0] req_word;
  logic [DATA_W-1:0]  req_data;

  logic               pend_v;
  op_kind_t           pend_kind;
  logic [BLK_AW-1:0]  pend_blk;
  logic [WORD_AW-1:0] pend_word;
  logic [DATA_W-1:0]  pend_data;

  logic               prog_busy, prog_wr;
  logic [BLK_AW-1:0]  prog_blk;
  logic [WORD_AW-1:0] prog_word;
  logic [DATA_W-1:0]  prog_data;
  logic               erase_busy, erase_run, erase_wipe;
  logic [BLK_AW-1:0]  erase_blk;

  logic refuse, take, overflow, go_prog, go_erase, busy;
  logic seq_err, prog_fail, erase_fail;

  flq_cmd_decode #(.BLK_AW(BLK_AW), .WORD_AW(WORD_AW), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .req_valid(req_valid), .req_kind(req_kind),
    .req_blk(req_blk), .req_word(req_word), .req_data(req_data),
    .lock_set(lock_set), .lock_clr(lock_clr), .clr_stat(clr_stat),
    .bad_seq(bad_seq)
  );

  assign refuse   = req_valid && (req_kind != OP_EALL) && blk_lock[req_blk] && wr_protect;
  assign take     = req_valid && !refuse && !pend_v;
  assign overflow = req_valid && !refuse && pend_v;

  always_comb begin
    go_prog  = 1'b0;
    go_erase = 1'b0;
    if (pend_v) begin
      case (pend_kind)
        OP_PROG:  go_prog  = !prog_busy && !(erase_busy && erase_blk == pend_blk);
        OP_ERASE: go_erase = !erase_busy && !(prog_busy && prog_blk == pend_blk);
        default:  go_erase = !erase_busy;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_kind <= OP_PROG;
      pend_blk  <= '0;
      pend_word <= '0;
      pend_data <= '0;
    end else if (take) begin
      pend_v    <= 1'b1;
      pend_kind <= req_kind;
      pend_blk  <= req_blk;
      pend_word <= req_word;
      pend_data <= req_data;
    end else if (go_prog || go_erase) begin
      pend_v <= 1'b0;
    end
  end

  flq_prog_eng #(.BLK_AW(BLK_AW), .WORD_AW(WORD_AW), .DATA_W(DATA_W),
                 .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(go_prog), .blk(pend_blk),
    .word(pend_word), .data(pend_data), .busy(prog_busy), .cur_blk(prog_blk),
    .wr_en(prog_wr), .wr_word(prog_word), .wr_data(prog_data)
  );

  flq_erase_eng #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW),
                  .ERASE_CYCLES(ERASE_CYCLES)) u_erase (
    .clk(clk), .rst_n(rst_n), .start(go_erase), .all_mode(pend_kind == OP_EALL),
    .blk(pend_blk), .lock(blk_lock), .prog_busy(prog_busy), .prog_blk(prog_blk),
    .busy(erase_busy), .running(erase_run), .cur_blk(erase_blk),
    .wipe_en(erase_wipe)
  );

  flq_array #(.NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
              .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_wr), .wr_blk(prog_blk),
    .wr_word(prog_word), .wr_data(prog_data), .wipe_en(erase_wipe),
    .wipe_blk(erase_blk), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_lock   <= '0;
      blk_fail   <= '0;
      seq_err    <= 1'b0;
      prog_fail  <= 1'b0;
      erase_fail <= 1'b0;
    end else begin
      if (lock_set) blk_lock[req_blk] <= 1'b1;
      if (lock_clr) blk_lock[req_blk] <= 1'b0;
      if (clr_stat) begin
        blk_fail   <= '0;
        seq_err    <= 1'b0;
        prog_fail  <= 1'b0;
        erase_fail <= 1'b0;
      end else begin
        if (overflow || bad_seq) seq_err <= 1'b1;
        if (refuse) begin
          blk_fail[req_blk] <= 1'b1;
          if (req_kind == OP_PROG) prog_fail  <= 1'b1;
          else                     erase_fail <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    blk_busy = '0;
    if (prog_busy) blk_busy[prog_blk]  = 1'b1;
    if (erase_run) blk_busy[erase_blk] = 1'b1;
  end

  assign busy      = pend_v || prog_busy || erase_busy;
  assign busy_n    = !busy;
  assign cmd_ready = 1'b1;
  assign csr = {!busy, 1'b0, erase_fail, prog_fail, seq_err, 3'b000};
  assign gsr = {!busy, 3'b000, pend_v, erase_busy, prog_busy, seq_err};
endmodule

// File: rtl/flq_seq_chk.sv
module flq_seq_chk
  import flq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_AW     = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input op_kind_t              req_kind,
  input logic [BLK_AW-1:0]     req_blk,
  input logic                  clr_stat,
  input logic                  wr_protect,
  input logic                  prog_busy,
  input logic [BLK_AW-1:0]     prog_blk,
  input logic                  erase_run,
  input logic [BLK_AW-1:0]     erase_blk,
  input logic                  busy_n,
  input logic [7:0]            gsr,
  input logic [NUM_BLOCKS-1:0] blk_lock,
  input logic [NUM_BLOCKS-1:0] blk_fail
);
  AST_DISJOINT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && erase_run) |-> (prog_blk != erase_blk)); // R5

  AST_QUEUE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_EALL && gsr[3]) |=> gsr[0]); // R4

  AST_REFUSE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != OP_EALL && wr_protect && blk_lock[req_blk])
      |=> blk_fail[$past(req_blk)]); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stat |=> ((blk_fail & $past(blk_fail)) == $past(blk_fail))); // R10

  AST_BUSY_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == OP_EALL) |=> !busy_n); // R8
endmodule

bind flq_seq flq_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_blk(req_blk), .clr_stat(clr_stat), .wr_protect(wr_protect),
  .prog_busy(prog_busy), .prog_blk(prog_blk), .erase_run(erase_run),
  .erase_blk(erase_blk), .busy_n(busy_n), .gsr(gsr), .blk_lock(blk_lock),
  .blk_fail(blk_fail)
);

// File: tb/flq_seq_tb_top.sv
module flq_seq_tb_top;
  localparam int NB = 16;
  localparam int WPB = 8;
  localparam int DW = 16;
  localparam int PC = 4;
  localparam int EC = 12;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic wr_protect = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic busy_n;
  logic [7:0] csr, gsr;
  logic [NB-1:0] blk_lock, blk_fail, blk_busy;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flq_seq #(.NUM_BLOCKS(NB), .WORDS_PER_BLOCK(WPB), .DATA_W(DW),
            .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wr_protect(wr_protect),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy_n(busy_n), .csr(csr),
    .gsr(gsr), .blk_lock(blk_lock), .blk_fail(blk_fail), .blk_busy(blk_busy)
  );

  function automatic logic [AW-1:0] mk(input int b, input int w);
    return {4'(b), 3'(w)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_addr  = a;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input int b, input int w, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = mk(b, w);
    #1 v = rd_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (busy_n) return;
      @(negedge clk);
    end
    chk("R8 idle timeout busy_n", 32'(busy_n), 32'd1);
  endtask

  task automatic prog(input int b, input int w, input logic [DW-1:0] d);
    wr(mk(0, 0), 16'h0040);
    wr(mk(b, w), d);
  endtask

  task automatic erase(input int b);
    wr(mk(0, 0), 16'h0020);
    wr(mk(b, 0), 16'h00D0);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R13 busy_n", 32'(busy_n), 32'd1);
    chk("R13 R9 csr", 32'(csr), 32'h80);
    chk("R13 R9 gsr", 32'(gsr), 32'h80);
    chk("R13 lock", 32'(blk_lock), 32'h0);
    chk("R13 fail", 32'(blk_fail), 32'h0);
    rd(0, 0, v);   chk("R13 array b0", 32'(v), 32'hFFFF);
    rd(15, 7, v);  chk("R13 array b15", 32'(v), 32'hFFFF);
    chk("R12 cmd_ready", 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_program();
    logic [DW-1:0] v;
    prog(1, 3, 16'hA5F0);
    wait_idle();
    rd(1, 3, v);  chk("R1 R3 first program", 32'(v), 32'hA5F0);
    prog(1, 3, 16'h0FFF);
    wait_idle();
    rd(1, 3, v);  chk("R3 AND merge", 32'(v), 32'h05F0);
    rd(1, 2, v);  chk("R3 neighbour word", 32'(v), 32'hFFFF);
  endtask

  task automatic t_duration();
    int cnt;
    cnt = 0;
    prog(4, 0, 16'h1234);
    for (int i = 0; i < 40; i++) begin
      if (gsr[1]) cnt++;
      @(negedge clk);
    end
    chk("R11 program cycles", 32'(cnt), 32'(PC));
    cnt = 0;
    erase(4);
    for (int i = 0; i < 60; i++) begin
      if (gsr[2]) cnt++;
      @(negedge clk);
    end
    chk("R11 erase cycles", 32'(cnt), 32'(EC));
  endtask

  task automatic t_erase();
    logic [DW-1:0] v;
    prog(6, 1, 16'h00FF);
    wait_idle();
    erase(1);
    wait_idle();
    rd(1, 3, v);  chk("R2 erased word", 32'(v), 32'hFFFF);
    rd(6, 1, v);  chk("R2 other block kept", 32'(v), 32'h00FF);
    rd(4, 0, v);  chk("R2 earlier erase", 32'(v), 32'hFFFF);
  endtask

  task automatic t_bad_seq();
    wr(mk(2, 0), 16'h0020);
    wr(mk(2, 0), 16'h0033);
    chk("R1 bad confirm csr", 32'(csr), 32'h88);
    chk("R1 bad confirm busy_n", 32'(busy_n), 32'd1);
    wr(mk(0, 0), 16'h0050);
    chk("R10 clear status", 32'(csr), 32'h80);
  endtask

  task automatic t_queue();
    logic [DW-1:0] v;
    erase(2);
    erase(3);
    chk("R4 queue full", 32'(gsr[3]), 32'd1);
    chk("R8 busy while queued", 32'(busy_n), 32'd0);
    chk("R12 ready while busy", 32'(cmd_ready), 32'd1);
    prog(5, 0, 16'h0000);
    chk("R4 overflow seq err", 32'(gsr[0]), 32'd1);
    wait_idle();
    rd(5, 0, v);  chk("R4 dropped op", 32'(v), 32'hFFFF);
    chk("R8 ready after drain", 32'(busy_n), 32'd1);
    wr(mk(0, 0), 16'h0050);
  endtask

  task automatic t_concurrent();
    logic [DW-1:0] v;
    erase(8);
    prog(9, 0, 16'h5A5A);
    @(negedge clk);
    chk("R5 both engines", 32'(gsr[2:1]), 32'h3);
    chk("R5 block busy", 32'(blk_busy), 32'h0300);
    wait_idle();
    rd(9, 0, v);  chk("R5 concurrent program", 32'(v), 32'h5A5A);
    erase(8);
    prog(8, 1, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    chk("R5 program waits", 32'({gsr[3], gsr[1]}), 32'h2);
    wait_idle();
    rd(8, 1, v);  chk("R5 program after erase", 32'(v), 32'h0000);
  endtask

  task automatic t_lock();
    logic [DW-1:0] v;
    wr(mk(0, 0), 16'h0060);
    wr(mk(10, 0), 16'h0001);
    chk("R6 lock set", 32'(blk_lock), 32'h0400);
    wr_protect = 1'b1;
    prog(10, 0, 16'h0000);
    chk("R6 R9 program refused csr", 32'(csr), 32'h90);
    chk("R6 fail bit", 32'(blk_fail), 32'h0400);
    rd(10, 0, v);  chk("R6 array kept", 32'(v), 32'hFFFF);
    erase(10);
    chk("R6 R9 erase refused csr", 32'(csr), 32'hB0);
    wait_idle();
    chk("R10 fail sticky", 32'(blk_fail), 32'h0400);
    wr(mk(0, 0), 16'h0050);
    chk("R10 fail cleared", 32'(blk_fail), 32'h0);
    wr_protect = 1'b0;
    prog(10, 0, 16'h1111);
    wait_idle();
    rd(10, 0, v);  chk("R6 unprotected locked block", 32'(v), 32'h1111);
  endtask

  task automatic t_erase_all();
    logic [DW-1:0] v;
    prog(11, 0, 16'h2222);
    wait_idle();
    wr_protect = 1'b1;
    wr(mk(0, 0), 16'h00A7);
    wr(mk(0, 0), 16'h00D0);
    wait_idle();
    rd(10, 0, v);  chk("R7 locked block skipped", 32'(v), 32'h1111);
    rd(11, 0, v);  chk("R7 unlocked erased", 32'(v), 32'hFFFF);
    rd(6, 1, v);   chk("R7 low block erased", 32'(v), 32'hFFFF);
    chk("R7 no fail", 32'(blk_fail), 32'h0);
    wr_protect = 1'b0;
    wr(mk(0, 0), 16'h0060);
    wr(mk(10, 0), 16'h00D0);
    chk("R6 lock cleared", 32'(blk_lock), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_duration();
    t_erase();
    t_bad_seq();
    t_queue();
    t_concurrent();
    t_lock();
    t_erase_all();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R8 watchdog busy_n actual=%0b expected=1", busy_n);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule